// File: doc/BRIEF.md
# A/B Toggle Update Controller

This block decides, for each channel of a multi-channel DAC, when the channel's output register reloads and whether it reloads from alternate input register A or B. It holds a per-channel toggle-select mask and a software global toggle bit. It also samples an asynchronous toggle pin into the system clock domain. The bit and the synchronized pin are ANDed into one joint toggle signal, and only edges of that joint signal act. A falling edge reloads every selected channel from A. A rising edge reloads every selected channel from B. Channels whose select bit is clear are never touched by a toggle event.

The same mask also steers code writes. A write aimed at a selected channel lands in that channel's B register. A write to an unselected channel lands in its A register. A broadcast update reloads every channel at once: unselected channels take A and selected channels take B. All outputs are registered, one-cycle strobes that go to the channel register bank.

Top module: `ab_toggle_ctrl`

## Requirements
- R1: After reset, no update or write strobe is active, the select mask is all zero, and the global toggle bit is 1, so pin edges act without any software setup.
- R2: A select write loads mask bit x from data bit x for x below NUM_CH. Data bits above NUM_CH-1 are ignored.
- R3: A code write to channel c gives exactly one strobe on the next cycle: `code_wr_b[c]` if mask bit c is 1, otherwise `code_wr_a[c]`.
- R4: With the global bit at 1, a falling pin edge gives a one-cycle `upd_stb` equal to the mask, with `upd_src_b` at 0 (load A). The strobe appears on the third clock edge after the pin changes.
- R5: With the global bit at 1, a rising pin edge gives the same strobe with `upd_src_b` equal to the mask (load B).
- R6: With the pin high, writing the global bit from 1 to 0 strobes the selected channels from A, and writing it from 0 to 1 strobes them from B. The strobe comes one cycle after the registered write.
- R7: Rewriting the global bit with its current value, or holding the pin at a steady level, gives no strobe.
- R8: While the global bit is 0, pin edges give no strobe. While the pin is low, global-bit writes give no strobe.
- R9: A broadcast update gives, on the next cycle, a strobe on every channel, with `upd_src_b` equal to the mask.
- R10: A low `clr_n` clears the mask on the next edge and takes priority over a select write in the same cycle. It leaves the global bit unchanged.
- R11: If a toggle edge and a broadcast update are resolved in the same cycle, every channel is strobed. Selected channels take the toggle edge's direction, and unselected channels take A.
- R12: A code write that coincides with a select write is steered by the mask value held before that select write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_n | input | 1 | Synchronous active-low clear of the select mask |
| sel_wr | input | 1 | Select-mask write strobe |
| sel_wdata | input | DATA_W | Select-mask write data; the low NUM_CH bits are used |
| gtb_wr | input | 1 | Global toggle bit write strobe |
| gtb_wdata | input | 1 | Global toggle bit write value |
| tgl_pin | input | 1 | Asynchronous toggle pin |
| code_wr | input | 1 | Code write strobe |
| code_ch | input | ADDR_W | Channel addressed by the code write |
| bcast_upd | input | 1 | Broadcast update strobe (all channels) |
| upd_stb | output | NUM_CH | Per-channel output-register reload strobe |
| upd_src_b | output | NUM_CH | Per-channel reload source: 1 = B, 0 = A |
| code_wr_a | output | NUM_CH | Per-channel write strobe into input register A |
| code_wr_b | output | NUM_CH | Per-channel write strobe into input register B |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a toggle edge and a broadcast update. The bench writes the global bit from 1 to 0 with the pin high and then issues a broadcast one cycle later, so that both reach the output register on the same edge. In that cycle every strobe must be set and every source must be A; a broadcast alone would have picked B for the selected channels. The second pair is a select write issued together with a code write. The bench judges this pair by which of the A or B write strobes fires, which must follow the mask as it stood before the select write.

// File: rtl/ab_tgl_pkg.sv
// Package: types shared by the toggle controller and its submodules.
// Assumes: nothing beyond IEEE 1800-2017.
package ab_tgl_pkg;

    // Edge events on the joint toggle signal
    typedef struct packed {
        logic rise;
        logic fall;
    } tgl_edge_t;

endpackage

// File: rtl/ab_tgl_sync.sv
// Module: two-flop synchronizer bringing the asynchronous toggle pin
// into the system clock domain.
// Assumes: the pin holds each level for well over two clock periods.
module ab_tgl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);

    logic [STAGES-1:0] chain;

    // Shift the pin through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], d_async};
        end
    end

    assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/ab_tgl_edge.sv
// Module: edge detector on the joint toggle signal (global bit AND pin).
// Each transition of the input gives exactly one single-cycle event.
// Assumes: the input is already synchronous to clk.
module ab_tgl_edge
    import ab_tgl_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      lvl,
    output tgl_edge_t edge_o
);

    logic lvl_q;

    // Remember the previous level of the joint toggle signal
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= 1'b0;
        end else begin
            lvl_q <= lvl;
        end
    end

    // Compare the current and previous levels to find edges
    always_comb begin
        edge_o.rise = lvl & ~lvl_q;
        edge_o.fall = ~lvl & lvl_q;
    end

endmodule

// File: rtl/ab_tgl_route.sv
// Module: per-channel router. It turns toggle events and broadcast
// updates into registered reload strobes and A/B source selects, and
// steers code writes to register A or B.
// Assumes: sel is the registered mask; all outputs are one-cycle pulses.
module ab_tgl_route
    import ab_tgl_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int ADDR_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] sel,
    input  tgl_edge_t         edge_i,
    input  logic              bcast,
    input  logic              code_wr,
    input  logic [ADDR_W-1:0] code_ch,
    output logic [NUM_CH-1:0] upd_stb,
    output logic [NUM_CH-1:0] upd_src_b,
    output logic [NUM_CH-1:0] code_wr_a,
    output logic [NUM_CH-1:0] code_wr_b
);

    logic tgl_any;

    assign tgl_any = edge_i.rise | edge_i.fall;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        logic stb_n, src_n, hit_n;

        // Decide the reload and its source for this channel
        always_comb begin
            stb_n = bcast | (tgl_any & sel[ch]);
            src_n = sel[ch] & (tgl_any ? edge_i.rise : bcast);
            hit_n = code_wr & (code_ch == ADDR_W'(ch));
        end

        // Register the strobes for this channel
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                upd_stb[ch]   <= 1'b0;
                upd_src_b[ch] <= 1'b0;
                code_wr_a[ch] <= 1'b0;
                code_wr_b[ch] <= 1'b0;
            end else begin
                upd_stb[ch]   <= stb_n;
                upd_src_b[ch] <= src_n;
                code_wr_a[ch] <= hit_n & ~sel[ch];
                code_wr_b[ch] <= hit_n & sel[ch];
            end
        end
    end

endmodule

// File: rtl/ab_toggle_ctrl.sv
// Module: top of the A/B toggle update controller. It holds the select
// mask and the global toggle bit, synchronizes the toggle pin, detects
// edges of (global bit AND pin), and routes the results per channel.
// Assumes: the control write strobes are synchronous single-cycle pulses.
module ab_toggle_ctrl
    import ab_tgl_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int DATA_W = 16,
    parameter int ADDR_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_n,
    input  logic              sel_wr,
    input  logic [DATA_W-1:0] sel_wdata,
    input  logic              gtb_wr,
    input  logic              gtb_wdata,
    input  logic              tgl_pin,
    input  logic              code_wr,
    input  logic [ADDR_W-1:0] code_ch,
    input  logic              bcast_upd,
    output logic [NUM_CH-1:0] upd_stb,
    output logic [NUM_CH-1:0] upd_src_b,
    output logic [NUM_CH-1:0] code_wr_a,
    output logic [NUM_CH-1:0] code_wr_b
);

    logic [NUM_CH-1:0] sel_q;
    logic              gtb_q;
    logic              pin_s;
    tgl_edge_t         tgl_edge;
    logic              unused_hi;

    assign unused_hi = ^sel_wdata[DATA_W-1:NUM_CH];

    // Select mask: cleared by reset or clear, else loaded on write
    always_ff @(posedge clk) begin
        if (!rst_n || !clr_n) begin
            sel_q <= '0;
        end else if (sel_wr) begin
            sel_q <= sel_wdata[NUM_CH-1:0];
        end
    end

    // Global toggle bit: starts at 1 so the pin works without setup
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gtb_q <= 1'b1;
        end else if (gtb_wr) begin
            gtb_q <= gtb_wdata;
        end
    end

    ab_tgl_sync #(.STAGES(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (tgl_pin),
        .q_sync  (pin_s)
    );

    ab_tgl_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl    (gtb_q & pin_s),
        .edge_o (tgl_edge)
    );

    ab_tgl_route #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_route (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (sel_q),
        .edge_i    (tgl_edge),
        .bcast     (bcast_upd),
        .code_wr   (code_wr),
        .code_ch   (code_ch),
        .upd_stb   (upd_stb),
        .upd_src_b (upd_src_b),
        .code_wr_a (code_wr_a),
        .code_wr_b (code_wr_b)
    );

endmodule

// File: rtl/ab_toggle_ctrl_chk.sv
// Module: assertion checker bound to ab_toggle_ctrl.
// Assumes: it is attached through the bind below and sees sel_q.
module ab_toggle_ctrl_chk #(
    parameter int NUM_CH = 8,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clr_n,
    input logic              code_wr,
    input logic [ADDR_W-1:0] code_ch,
    input logic              bcast_upd,
    input logic [NUM_CH-1:0] sel_q,
    input logic [NUM_CH-1:0] upd_stb,
    input logic [NUM_CH-1:0] upd_src_b,
    input logic [NUM_CH-1:0] code_wr_a,
    input logic [NUM_CH-1:0] code_wr_b
);

    p_code_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({code_wr_b, code_wr_a}));

    p_code_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (code_wr && (int'(code_ch) < NUM_CH)) |=> $countones({code_wr_b, code_wr_a}) == 1);

    p_no_unselected_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bcast_upd) |-> ((upd_stb & ~$past(sel_q)) == '0));

    p_src_within_stb_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_src_b & ~upd_stb) == '0);

    p_bcast_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bcast_upd |=> (&upd_stb));

    p_src_from_mask_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_src_b & ~$past(sel_q)) == '0);

    p_clear_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |=> (sel_q == '0));

endmodule

bind ab_toggle_ctrl ab_toggle_ctrl_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_n     (clr_n),
    .code_wr   (code_wr),
    .code_ch   (code_ch),
    .bcast_upd (bcast_upd),
    .sel_q     (sel_q),
    .upd_stb   (upd_stb),
    .upd_src_b (upd_src_b),
    .code_wr_a (code_wr_a),
    .code_wr_b (code_wr_b)
);

// File: tb/ab_toggle_ctrl_bench.sv
// Bench: walks a vector table of operations and expected strobes, then
// runs directed tests for clear and mid-run reset.
module ab_toggle_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_CH = 8;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 3;

    // Operation codes used by the bench
    localparam logic [2:0] OP_SELW  = 3'd1;
    localparam logic [2:0] OP_GTBW  = 3'd2;
    localparam logic [2:0] OP_CODEW = 3'd3;
    localparam logic [2:0] OP_BCAST = 3'd4;
    localparam logic [2:0] OP_PIN   = 3'd5;
    localparam logic [2:0] OP_GTBBC = 3'd6;
    localparam logic [2:0] OP_SELCW = 3'd7;

    typedef struct packed {
        logic [2:0]  op;
        logic [15:0] data;
        logic [7:0]  req;
        logic [7:0]  stb;
        logic [7:0]  src;
        logic [7:0]  wa;
        logic [7:0]  wb;
    } vec_t;

    localparam int NVEC = 24;
    localparam vec_t VEC [NVEC] = '{
        '{OP_BCAST, 16'h0000,  9, 8'hFF, 8'h00, 8'h00, 8'h00}, // R1 R9
        '{OP_CODEW, 16'h0003,  3, 8'h00, 8'h00, 8'h08, 8'h00}, // R1 R3
        '{OP_SELW,  16'hFF0A,  2, 8'h00, 8'h00, 8'h00, 8'h00}, // R2
        '{OP_BCAST, 16'h0000,  2, 8'hFF, 8'h0A, 8'h00, 8'h00}, // R2 R9
        '{OP_CODEW, 16'h0003,  3, 8'h00, 8'h00, 8'h00, 8'h08}, // R3
        '{OP_CODEW, 16'h0002,  3, 8'h00, 8'h00, 8'h04, 8'h00}, // R3
        '{OP_PIN,   16'h0001,  5, 8'h0A, 8'h0A, 8'h00, 8'h00}, // R5
        '{OP_PIN,   16'h0001,  7, 8'h00, 8'h00, 8'h00, 8'h00}, // R7
        '{OP_PIN,   16'h0000,  4, 8'h0A, 8'h00, 8'h00, 8'h00}, // R4
        '{OP_PIN,   16'h0001,  5, 8'h0A, 8'h0A, 8'h00, 8'h00}, // R5
        '{OP_GTBW,  16'h0000,  6, 8'h0A, 8'h00, 8'h00, 8'h00}, // R6
        '{OP_GTBW,  16'h0000,  7, 8'h00, 8'h00, 8'h00, 8'h00}, // R7
        '{OP_PIN,   16'h0000,  8, 8'h00, 8'h00, 8'h00, 8'h00}, // R8
        '{OP_PIN,   16'h0001,  8, 8'h00, 8'h00, 8'h00, 8'h00}, // R8
        '{OP_GTBW,  16'h0001,  6, 8'h0A, 8'h0A, 8'h00, 8'h00}, // R6
        '{OP_GTBW,  16'h0001,  7, 8'h00, 8'h00, 8'h00, 8'h00}, // R7
        '{OP_PIN,   16'h0000,  4, 8'h0A, 8'h00, 8'h00, 8'h00}, // R4
        '{OP_GTBW,  16'h0000,  8, 8'h00, 8'h00, 8'h00, 8'h00}, // R8
        '{OP_GTBW,  16'h0001,  8, 8'h00, 8'h00, 8'h00, 8'h00}, // R8
        '{OP_PIN,   16'h0001,  5, 8'h0A, 8'h0A, 8'h00, 8'h00}, // R5
        '{OP_GTBBC, 16'h0000, 11, 8'hFF, 8'h00, 8'h00, 8'h00}, // R11
        '{OP_GTBW,  16'h0001,  6, 8'h0A, 8'h0A, 8'h00, 8'h00}, // R6
        '{OP_SELCW, 16'h0204, 12, 8'h00, 8'h00, 8'h04, 8'h00}, // R12
        '{OP_CODEW, 16'h0002, 12, 8'h00, 8'h00, 8'h00, 8'h04}  // R12
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              clr_n = 1'b1;
    logic              sel_wr = 1'b0;
    logic [DATA_W-1:0] sel_wdata = '0;
    logic              gtb_wr = 1'b0;
    logic              gtb_wdata = 1'b0;
    logic              tgl_pin = 1'b0;
    logic              code_wr = 1'b0;
    logic [ADDR_W-1:0] code_ch = '0;
    logic              bcast_upd = 1'b0;
    logic [NUM_CH-1:0] upd_stb, upd_src_b, code_wr_a, code_wr_b;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ab_toggle_ctrl #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ab_toggle_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_n     (clr_n),
        .sel_wr    (sel_wr),
        .sel_wdata (sel_wdata),
        .gtb_wr    (gtb_wr),
        .gtb_wdata (gtb_wdata),
        .tgl_pin   (tgl_pin),
        .code_wr   (code_wr),
        .code_ch   (code_ch),
        .bcast_upd (bcast_upd),
        .upd_stb   (upd_stb),
        .upd_src_b (upd_src_b),
        .code_wr_a (code_wr_a),
        .code_wr_b (code_wr_b)
    );

    // Compare all four outputs against expected values
    task automatic check(input int req, input logic [7:0] stb, input logic [7:0] src,
                         input logic [7:0] wa, input logic [7:0] wb);
        n_chk++;
        if (upd_stb !== stb || upd_src_b !== src || code_wr_a !== wa || code_wr_b !== wb) begin
            n_bad++;
            $display("FAIL R%0d: stb=%h src=%h wa=%h wb=%h expected stb=%h src=%h wa=%h wb=%h",
                     req, upd_stb, upd_src_b, code_wr_a, code_wr_b, stb, src, wa, wb);
        end
    endtask

    // Apply one operation and wait until its result is on the outputs
    task automatic run_op(input logic [2:0] op, input logic [15:0] data);
        int lat;
        @(negedge clk);
        lat = 0;
        case (op)
            OP_SELW:  begin sel_wr = 1'b1; sel_wdata = data; end
            OP_GTBW:  begin gtb_wr = 1'b1; gtb_wdata = data[0]; lat = 1; end
            OP_CODEW: begin code_wr = 1'b1; code_ch = data[2:0]; end
            OP_BCAST: bcast_upd = 1'b1;
            OP_PIN:   begin tgl_pin = data[0]; lat = 2; end
            OP_GTBBC: begin gtb_wr = 1'b1; gtb_wdata = data[0]; lat = 1; end
            OP_SELCW: begin sel_wr = 1'b1; sel_wdata = {8'h00, data[7:0]};
                            code_wr = 1'b1; code_ch = data[10:8]; end
            default:  ;
        endcase
        @(negedge clk);
        sel_wr = 1'b0; gtb_wr = 1'b0; code_wr = 1'b0; bcast_upd = 1'b0;
        if (op == OP_GTBBC) bcast_upd = 1'b1;
        for (int i = 0; i < lat; i++) begin
            @(negedge clk);
            bcast_upd = 1'b0;
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        #(CLK_PERIOD * 20000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(1, 8'h00, 8'h00, 8'h00, 8'h00); // R1: outputs idle in reset
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(1, 8'h00, 8'h00, 8'h00, 8'h00); // R1: idle after release

        // Vector walk: result check, then one-cycle pulse check
        for (int v = 0; v < NVEC; v++) begin
            run_op(VEC[v].op, VEC[v].data);
            check(int'(VEC[v].req), VEC[v].stb, VEC[v].src, VEC[v].wa, VEC[v].wb);
            @(negedge clk);
            check(int'(VEC[v].req), 8'h00, 8'h00, 8'h00, 8'h00);
        end

        // R10: clear wins over a same-cycle select write
        @(negedge clk);
        clr_n = 1'b0; sel_wr = 1'b1; sel_wdata = 16'h00FF;
        @(negedge clk);
        clr_n = 1'b1; sel_wr = 1'b0;
        run_op(OP_BCAST, 16'h0000);
        check(10, 8'hFF, 8'h00, 8'h00, 8'h00);
        // R10: global bit kept at 1, so the pin still toggles
        run_op(OP_SELW, 16'h0001);
        run_op(OP_PIN, 16'h0000);
        check(10, 8'h01, 8'h00, 8'h00, 8'h00);

        // R1: mid-run reset restores mask 0 and global bit 1
        run_op(OP_SELW, 16'h00F0);
        run_op(OP_GTBW, 16'h0000);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(1, 8'h00, 8'h00, 8'h00, 8'h00);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        run_op(OP_BCAST, 16'h0000);
        check(1, 8'hFF, 8'h00, 8'h00, 8'h00);
        run_op(OP_SELW, 16'h0002);
        run_op(OP_PIN, 16'h0001);
        check(1, 8'h02, 8'h02, 8'h00, 8'h00);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule